// File: doc/BRIEF.md
# Six-Instruction Load-Store Processor Core

This block is a small programmable processor. It runs programs held in a 16-bit-wide instruction memory. The datapath has a 16-entry register file, an adder/subtractor and a 256-word data memory. A multi-cycle controller handles each instruction in three stages, one clock each: fetch, decode and execute. Data moves between the data memory and the registers only through load and store instructions. The arithmetic unit reads and writes registers only.

Each instruction is 16 bits. The opcode sits in the top four bits. The six operations are:

- load from memory
- store to memory
- add
- subtract
- load an 8-bit constant
- branch by a relative offset when a register holds zero

Both memories are synchronous arrays inside the core, and the testbench preloads them. The ports show the program counter, the current stage and the data-memory write strobe with its address and data. A store therefore makes any register value visible at the ports.

Top module: `lsproc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and the stage to fetch (stage code 0).
- R2: The stage code on `stage_o` steps 0 (fetch) → 1 (decode) → 2 (execute) → 0. The program counter rises by one at the end of fetch. It does not change during decode.
- R3: Opcode 0000 loads a register. Bits [11:8] name the destination register and bits [7:0] give the data address: R[r] = D[d]. This works for every address, including 8'hFF.
- R4: Opcode 0001 stores a register, with the same field layout as load. During execute it raises `dm_we_o` for exactly one cycle, with `dm_addr_o` = bits [7:0] and `dm_wdata_o` = R[bits 11:8].
- R5: Opcode 0010 adds: R[11:8] = R[7:4] + R[3:0], modulo 2^16.
- R6: Opcode 0011 loads bits [7:0], zero-extended to 16 bits, into R[11:8].
- R7: Opcode 0100 subtracts: R[11:8] = R[7:4] − R[3:0], modulo 2^16.
- R8: Opcode 0101 is jump-if-zero. When R[11:8] is zero, the next fetch comes from the jump's own address plus bits [7:0], read as a two's-complement offset. Backward offsets and offset 0 (a jump to itself) are included.
- R9: When the jump-if-zero register is not zero, execution continues at the next address.
- R10: Opcodes 0110 to 1111 are no-ops. They write no register and no memory, and execution continues at the next address.
- R11: `dm_we_o` is high only in the execute stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pc_o | output | 8 | Program counter |
| stage_o | output | 2 | Stage code: 0 fetch, 1 decode, 2 execute |
| dm_we_o | output | 1 | Data-memory write strobe |
| dm_addr_o | output | 8 | Data-memory address |
| dm_wdata_o | output | 16 | Data-memory write data |

## Verification
Two things can land in the same execute cycle: the register-file write of one instruction and the store or zero test of the next instruction, which reads that register straight back. The fetch increment and a taken jump also both update the program counter, so the jump target must be taken relative to the jump's own address and not the incremented one.

The bench tests these overlaps in several ways:
- It places a store, or a jump-if-zero, directly after the instruction that writes the same register.
- It runs a countdown loop with a negative offset.
- It ends each program with a zero-offset self-jump.

It judges the results by the stored values, the number of store strobes and the program counter seen in each fetch stage.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
   localparam int INSTR_W = 16;
   localparam int OPC_W   = 4;

   localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h0;
   localparam logic [OPC_W-1:0] OPC_STORE = 4'h1;
   localparam logic [OPC_W-1:0] OPC_ADD   = 4'h2;
   localparam logic [OPC_W-1:0] OPC_CONST = 4'h3;
   localparam logic [OPC_W-1:0] OPC_SUB   = 4'h4;
   localparam logic [OPC_W-1:0] OPC_JZ    = 4'h5;

   typedef enum logic [1:0] {
      ST_FETCH  = 2'd0,
      ST_DECODE = 2'd1,
      ST_EXEC   = 2'd2
   } stage_e;

   typedef enum logic [1:0] {
      WB_ALU   = 2'd0,
      WB_MEM   = 2'd1,
      WB_CONST = 2'd2
   } wb_sel_e;
endpackage

// File: rtl/lsp_sram.sv
module lsp_sram #(
   parameter int AW = 8,
   parameter int DW = 16,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk_i,
   input  logic          rd_en_i,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] rdata_o
);
   logic [DW-1:0] mem_q [DEPTH];

   always_ff @(posedge clk_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
   end

   always_ff @(posedge clk_i) begin
      if (rd_en_i) rdata_o <= mem_q[addr_i];
   end
endmodule

// File: rtl/lsp_regfile.sv
module lsp_regfile #(
   parameter int AW = 4,
   parameter int DW = 16,
   localparam int NREG = 1 << AW
) (
   input  logic          clk_i,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [AW-1:0] raddr_a_i,
   input  logic [AW-1:0] raddr_b_i,
   input  logic [AW-1:0] raddr_c_i,
   output logic [DW-1:0] rdata_a_o,
   output logic [DW-1:0] rdata_b_o,
   output logic [DW-1:0] rdata_c_o
);
   logic [DW-1:0] regs_q [NREG];

   always_ff @(posedge clk_i) begin
      if (we_i) regs_q[waddr_i] <= wdata_i;
   end

   assign rdata_a_o = regs_q[raddr_a_i];
   assign rdata_b_o = regs_q[raddr_b_i];
   assign rdata_c_o = regs_q[raddr_c_i];
endmodule

// File: rtl/lsp_alu.sv
module lsp_alu #(
   parameter int W          = 16,
   parameter bit ONE_ADDER  = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sub_i,
   output logic [W-1:0] y_o
);
   generate
      if (ONE_ADDER) begin : g_shared
         // subtract as a + ~b + 1 through a single carry chain
         assign y_o = a_i + (b_i ^ {W{sub_i}}) + W'(sub_i);
      end else begin : g_split
         logic [W-1:0] sum, dif;
         assign sum = a_i + b_i;
         assign dif = a_i - b_i;
         assign y_o = sub_i ? dif : sum;
      end
   endgenerate
endmodule

// File: rtl/lsp_ctrl.sv
module lsp_ctrl
   import lsp_pkg::*;
#(
   parameter int PC_W = 8
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic [INSTR_W-1:0] ir_i,
   input  logic               reg_zero_i,
   output logic [PC_W-1:0]    pc_o,
   output stage_e             stage_o,
   output logic               im_rd_en_o,
   output logic               dm_rd_en_o,
   output logic               dm_we_o,
   output logic               rf_we_o,
   output wb_sel_e            wb_sel_o,
   output logic               alu_sub_o
);
   stage_e            state_q;
   logic [PC_W-1:0]   pc_q;
   logic [OPC_W-1:0]  opc;
   logic [PC_W-1:0]   jump_tgt;
   logic              is_known;

   assign opc      = ir_i[INSTR_W-1 -: OPC_W];
   // offset counts from the jump's own address, one below the incremented PC
   assign jump_tgt = pc_q - PC_W'(1) + PC_W'(signed'(ir_i[7:0]));
   assign is_known = (opc == OPC_LOAD) || (opc == OPC_STORE) || (opc == OPC_ADD) ||
                     (opc == OPC_CONST) || (opc == OPC_SUB) || (opc == OPC_JZ);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= ST_FETCH;
         pc_q    <= '0;
      end else begin
         unique case (state_q)
            ST_FETCH: begin
               state_q <= ST_DECODE;
               pc_q    <= pc_q + PC_W'(1);
            end
            ST_DECODE: state_q <= ST_EXEC;
            default: begin
               state_q <= ST_FETCH;
               if (opc == OPC_JZ && reg_zero_i) pc_q <= jump_tgt;
            end
         endcase
      end
   end

   always_comb begin
      im_rd_en_o = (state_q == ST_FETCH);
      dm_rd_en_o = (state_q == ST_DECODE) && (opc == OPC_LOAD);
      dm_we_o    = (state_q == ST_EXEC) && (opc == OPC_STORE);
      rf_we_o    = (state_q == ST_EXEC) &&
                   ((opc == OPC_LOAD) || (opc == OPC_ADD) ||
                    (opc == OPC_CONST) || (opc == OPC_SUB));
      alu_sub_o  = (opc == OPC_SUB);
      unique case (opc)
         OPC_LOAD:  wb_sel_o = WB_MEM;
         OPC_CONST: wb_sel_o = WB_CONST;
         default:   wb_sel_o = WB_ALU;
      endcase
   end

   assign pc_o    = pc_q;
   assign stage_o = state_q;

   // ---------------- assertions ----------------
   a_r1_reset_state: assert property (@(posedge clk_i)
      rst_i |=> (pc_q == '0 && state_q == ST_FETCH));

   a_r2_fetch_to_decode: assert property (@(posedge clk_i) disable iff (rst_i)
      state_q == ST_FETCH |=> state_q == ST_DECODE);

   a_r2_decode_to_exec: assert property (@(posedge clk_i) disable iff (rst_i)
      state_q == ST_DECODE |=> state_q == ST_EXEC);

   a_r2_exec_to_fetch: assert property (@(posedge clk_i) disable iff (rst_i)
      state_q == ST_EXEC |=> state_q == ST_FETCH);

   a_r2_pc_step: assert property (@(posedge clk_i) disable iff (rst_i)
      state_q == ST_FETCH |=> pc_q == $past(pc_q) + PC_W'(1));

   a_r2_pc_hold_decode: assert property (@(posedge clk_i) disable iff (rst_i)
      state_q == ST_DECODE |=> $stable(pc_q));

   a_r9_jz_not_taken: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == ST_EXEC && opc == OPC_JZ && !reg_zero_i) |=> $stable(pc_q));

   a_r10_undef_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == ST_EXEC && !is_known) |-> (!dm_we_o && !rf_we_o));

   a_r10_undef_pc: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == ST_EXEC && !is_known) |=> $stable(pc_q));

   a_r11_we_in_exec: assert property (@(posedge clk_i) disable iff (rst_i)
      dm_we_o |-> state_q == ST_EXEC);

   a_r11_single_write_sel: assert property (@(posedge clk_i) disable iff (rst_i)
      !(dm_we_o && rf_we_o));
endmodule

// File: rtl/lsproc_core.sv
module lsproc_core
   import lsp_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int RF_AW     = 4,
   parameter int DM_AW     = 8,
   parameter int PC_W      = 8,
   parameter bit ONE_ADDER = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   output logic [PC_W-1:0]   pc_o,
   output logic [1:0]        stage_o,
   output logic              dm_we_o,
   output logic [DM_AW-1:0]  dm_addr_o,
   output logic [DATA_W-1:0] dm_wdata_o
);
   localparam int FIELD_W = INSTR_W - OPC_W;

   generate
      if (RF_AW != 4) begin : g_bad_rf
         $error("register select fields are 4 bits wide");
      end
      if (DM_AW != 8) begin : g_bad_dm
         $error("data address field is 8 bits wide");
      end
      if (PC_W < 8) begin : g_bad_pc
         $error("program counter must hold an 8-bit offset");
      end
      if (DATA_W < 8) begin : g_bad_dw
         $error("data width must hold an 8-bit constant");
      end
      if (FIELD_W != RF_AW + 8) begin : g_bad_fmt
         $error("operand field does not match encoding");
      end
   endgenerate

   logic [INSTR_W-1:0] ir;
   logic               im_rd_en, dm_rd_en, dm_we, rf_we, alu_sub;
   wb_sel_e            wb_sel;
   stage_e             stage;
   logic [PC_W-1:0]    pc;
   logic [DATA_W-1:0]  rf_a, rf_b, rf_c, alu_y, dm_rdata, rf_wdata;
   logic [DM_AW-1:0]   dm_addr;

   assign dm_addr = ir[DM_AW-1:0];

   // instruction memory: its read register doubles as the instruction register
   lsp_sram #(.AW(PC_W), .DW(INSTR_W)) u_imem (
      .clk_i   (clk_i),
      .rd_en_i (im_rd_en),
      .we_i    (1'b0),
      .addr_i  (pc),
      .wdata_i ('0),
      .rdata_o (ir)
   );

   lsp_sram #(.AW(DM_AW), .DW(DATA_W)) u_dmem (
      .clk_i   (clk_i),
      .rd_en_i (dm_rd_en),
      .we_i    (dm_we),
      .addr_i  (dm_addr),
      .wdata_i (rf_c),
      .rdata_o (dm_rdata)
   );

   lsp_regfile #(.AW(RF_AW), .DW(DATA_W)) u_rf (
      .clk_i     (clk_i),
      .we_i      (rf_we),
      .waddr_i   (ir[11:8]),
      .wdata_i   (rf_wdata),
      .raddr_a_i (ir[7:4]),
      .raddr_b_i (ir[3:0]),
      .raddr_c_i (ir[11:8]),
      .rdata_a_o (rf_a),
      .rdata_b_o (rf_b),
      .rdata_c_o (rf_c)
   );

   lsp_alu #(.W(DATA_W), .ONE_ADDER(ONE_ADDER)) u_alu (
      .a_i   (rf_a),
      .b_i   (rf_b),
      .sub_i (alu_sub),
      .y_o   (alu_y)
   );

   lsp_ctrl #(.PC_W(PC_W)) u_ctrl (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .ir_i       (ir),
      .reg_zero_i (rf_c == '0),
      .pc_o       (pc),
      .stage_o    (stage),
      .im_rd_en_o (im_rd_en),
      .dm_rd_en_o (dm_rd_en),
      .dm_we_o    (dm_we),
      .rf_we_o    (rf_we),
      .wb_sel_o   (wb_sel),
      .alu_sub_o  (alu_sub)
   );

   always_comb begin
      unique case (wb_sel)
         WB_MEM:   rf_wdata = dm_rdata;
         WB_CONST: rf_wdata = DATA_W'(ir[7:0]);
         default:  rf_wdata = alu_y;
      endcase
   end

   assign pc_o       = pc;
   assign stage_o    = stage;
   assign dm_we_o    = dm_we;
   assign dm_addr_o  = dm_addr;
   assign dm_wdata_o = rf_c;

   a_r4_store_fields: assert property (@(posedge clk_i) disable iff (rst_i)
      dm_we |-> (ir[15:12] == OPC_STORE && stage == ST_EXEC));

   a_r4_store_one_cycle: assert property (@(posedge clk_i) disable iff (rst_i)
      dm_we |=> !dm_we);
endmodule

// File: tb/lsproc_core_bench.sv
`timescale 1ns/1ps
module lsproc_core_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  pc;
   logic [1:0]  stage;
   logic        dm_we;
   logic [7:0]  dm_addr;
   logic [15:0] dm_wdata;

   always #2 clk = ~clk;

   lsproc_core u_lsproc_core (
      .clk_i(clk), .rst_i(rst), .pc_o(pc), .stage_o(stage),
      .dm_we_o(dm_we), .dm_addr_o(dm_addr), .dm_wdata_o(dm_wdata)
   );

   int n_run = 0, n_fail = 0;
   int wr_cnt = 0;
   logic [15:0] seen_data [256];
   logic        seen      [256];

   always @(negedge clk) begin
      if (!rst && dm_we) begin
         wr_cnt++;
         seen[dm_addr]      = 1'b1;
         seen_data[dm_addr] = dm_wdata;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] ins(input logic [3:0] op, input logic [3:0] r,
                                       input logic [7:0] lo);
      return {op, r, lo};
   endfunction

   // opcodes: 0 load, 1 store, 2 add, 3 const, 4 sub, 5 jump-if-zero
   task automatic clear_prog();
      for (int i = 0; i < 256; i++) u_lsproc_core.u_imem.mem_q[i] = 16'hF000;
   endtask

   task automatic boot(input int ncyc);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      wr_cnt = 0;
      for (int i = 0; i < 256; i++) begin
         seen[i] = 1'b0;
         seen_data[i] = 16'h0;
      end
      rst = 1'b0;
      repeat (ncyc) @(negedge clk);
   endtask

   task automatic pc_at_fetch(output logic [7:0] p);
      @(negedge clk);
      while (stage != 2'd0) @(negedge clk);
      p = pc;
   endtask

   // {opcode, a, b, expected}
   localparam logic [51:0] ALU_VEC [6] = '{
      {4'h2, 16'h0003, 16'h0004, 16'h0007},
      {4'h2, 16'hFFFF, 16'h0001, 16'h0000},
      {4'h2, 16'h8000, 16'h8000, 16'h0000},
      {4'h4, 16'h0005, 16'h0007, 16'hFFFE},
      {4'h4, 16'h1234, 16'h0234, 16'h1000},
      {4'h4, 16'h0000, 16'h0000, 16'h0000}
   };

   initial begin
      logic [7:0] p;

      // ---- R1: reset state
      clear_prog();
      u_lsproc_core.u_imem.mem_q[0] = ins(4'h3, 4'h0, 8'h00);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 pc after reset", pc, 8'h00);
      chk("R1 stage after reset", stage, 2'd0);

      // ---- R2: stage order and pc increment
      rst = 1'b0;
      @(negedge clk); chk("R2 decode stage", stage, 2'd1); chk("R2 pc after fetch", pc, 8'h01);
      @(negedge clk); chk("R2 exec stage", stage, 2'd2);   chk("R2 pc in exec", pc, 8'h01);
      @(negedge clk); chk("R2 back to fetch", stage, 2'd0);
      @(negedge clk); chk("R2 second fetch pc", pc, 8'h02);

      // ---- R5 R7 R3 R4: table walk
      foreach (ALU_VEC[k]) begin
         clear_prog();
         u_lsproc_core.u_dmem.mem_q[1] = ALU_VEC[k][35:20];
         u_lsproc_core.u_dmem.mem_q[2] = ALU_VEC[k][19:4] & 16'hFFFF;
         u_lsproc_core.u_dmem.mem_q[1] = ALU_VEC[k][47:32];
         u_lsproc_core.u_dmem.mem_q[2] = ALU_VEC[k][31:16];
         u_lsproc_core.u_imem.mem_q[0] = ins(4'h3, 4'h0, 8'h00);
         u_lsproc_core.u_imem.mem_q[1] = ins(4'h0, 4'h1, 8'h01);
         u_lsproc_core.u_imem.mem_q[2] = ins(4'h0, 4'h2, 8'h02);
         u_lsproc_core.u_imem.mem_q[3] = ins(ALU_VEC[k][51:48], 4'h3, 8'h12);
         u_lsproc_core.u_imem.mem_q[4] = ins(4'h1, 4'h3, 8'h80);
         u_lsproc_core.u_imem.mem_q[5] = ins(4'h5, 4'h0, 8'h00);
         boot(40);
         chk((ALU_VEC[k][51:48] == 4'h2) ? "R5 add result via R4 store" : "R7 sub result via R4 store",
             seen_data[8'h80], ALU_VEC[k][15:0]);
      end
      chk("R4 single store strobe", wr_cnt, 1);

      // ---- R3: load from top address, R6: constant zero-extended
      clear_prog();
      u_lsproc_core.u_dmem.mem_q[8'hFF] = 16'hBEEF;
      u_lsproc_core.u_imem.mem_q[0] = ins(4'h3, 4'h0, 8'h00);
      u_lsproc_core.u_imem.mem_q[1] = ins(4'h0, 4'h9, 8'hFF);
      u_lsproc_core.u_imem.mem_q[2] = ins(4'h1, 4'h9, 8'hFE);
      u_lsproc_core.u_imem.mem_q[3] = ins(4'h3, 4'h4, 8'hFF);
      u_lsproc_core.u_imem.mem_q[4] = ins(4'h1, 4'h4, 8'h10);
      u_lsproc_core.u_imem.mem_q[5] = ins(4'h5, 4'h0, 8'h00);
      boot(40);
      chk("R3 load from D[FF]", seen_data[8'hFE], 16'hBEEF);
      chk("R6 constant zero-extended", seen_data[8'h10], 16'h00FF);

      // ---- R8: forward jump taken, skipped store never happens
      clear_prog();
      u_lsproc_core.u_imem.mem_q[0] = ins(4'h3, 4'h0, 8'h00);
      u_lsproc_core.u_imem.mem_q[1] = ins(4'h5, 4'h0, 8'h03);
      u_lsproc_core.u_imem.mem_q[2] = ins(4'h3, 4'h5, 8'h11);
      u_lsproc_core.u_imem.mem_q[3] = ins(4'h1, 4'h5, 8'h20);
      u_lsproc_core.u_imem.mem_q[4] = ins(4'h3, 4'h5, 8'h22);
      u_lsproc_core.u_imem.mem_q[5] = ins(4'h1, 4'h5, 8'h21);
      u_lsproc_core.u_imem.mem_q[6] = ins(4'h5, 4'h0, 8'h00);
      boot(40);
      chk("R8 skipped store absent", seen[8'h20], 1'b0);
      chk("R8 target store value", seen_data[8'h21], 16'h0022);
      pc_at_fetch(p);
      chk("R8 zero offset self-jump pc", p, 8'h06);

      // ---- R9: not taken
      clear_prog();
      u_lsproc_core.u_imem.mem_q[0] = ins(4'h3, 4'h6, 8'h01);
      u_lsproc_core.u_imem.mem_q[1] = ins(4'h5, 4'h6, 8'h05);
      u_lsproc_core.u_imem.mem_q[2] = ins(4'h3, 4'h7, 8'h33);
      u_lsproc_core.u_imem.mem_q[3] = ins(4'h1, 4'h7, 8'h30);
      u_lsproc_core.u_imem.mem_q[4] = ins(4'h3, 4'h0, 8'h00);
      u_lsproc_core.u_imem.mem_q[5] = ins(4'h5, 4'h0, 8'h00);
      boot(40);
      chk("R9 fall-through store", seen_data[8'h30], 16'h0033);
      pc_at_fetch(p);
      chk("R9 halt pc", p, 8'h05);

      // ---- R8: backward offset countdown loop
      clear_prog();
      u_lsproc_core.u_imem.mem_q[0] = ins(4'h3, 4'h1, 8'h03);
      u_lsproc_core.u_imem.mem_q[1] = ins(4'h3, 4'h2, 8'h01);
      u_lsproc_core.u_imem.mem_q[2] = ins(4'h4, 4'h1, 8'h12);
      u_lsproc_core.u_imem.mem_q[3] = ins(4'h1, 4'h1, 8'h50);
      u_lsproc_core.u_imem.mem_q[4] = ins(4'h5, 4'h1, 8'h03);
      u_lsproc_core.u_imem.mem_q[5] = ins(4'h3, 4'h0, 8'h00);
      u_lsproc_core.u_imem.mem_q[6] = ins(4'h5, 4'h0, 8'hFC);
      u_lsproc_core.u_imem.mem_q[7] = ins(4'h5, 4'h0, 8'h00);
      boot(100);
      chk("R8 loop store count", wr_cnt, 3);
      chk("R8 loop final value", seen_data[8'h50], 16'h0000);

      // ---- R10: undefined opcodes are no-ops
      clear_prog();
      u_lsproc_core.u_imem.mem_q[0] = ins(4'h3, 4'h1, 8'h11);
      u_lsproc_core.u_imem.mem_q[1] = 16'h61FF;
      u_lsproc_core.u_imem.mem_q[2] = 16'hF1AB;
      u_lsproc_core.u_imem.mem_q[3] = ins(4'h1, 4'h1, 8'h61);
      u_lsproc_core.u_imem.mem_q[4] = ins(4'h3, 4'h0, 8'h00);
      u_lsproc_core.u_imem.mem_q[5] = ins(4'h5, 4'h0, 8'h00);
      boot(40);
      chk("R10 register untouched", seen_data[8'h61], 16'h0011);
      chk("R10 no memory write", wr_cnt, 1);
      pc_at_fetch(p);
      chk("R10 sequential pc", p, 8'h05);

      // ---- R11: strobe only in execute, sampled over a store-heavy run
      clear_prog();
      u_lsproc_core.u_imem.mem_q[0] = ins(4'h3, 4'h0, 8'h00);
      u_lsproc_core.u_imem.mem_q[1] = ins(4'h1, 4'h0, 8'h70);
      u_lsproc_core.u_imem.mem_q[2] = ins(4'h1, 4'h0, 8'h71);
      u_lsproc_core.u_imem.mem_q[3] = ins(4'h5, 4'h0, 8'h00);
      boot(0);
      begin
         int bad = 0;
         for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (dm_we && stage != 2'd2) bad++;
         end
         chk("R11 strobe outside execute", bad, 0);
      end

      // ---- R1: reset in the middle of a run
      rst = 1'b1;
      @(negedge clk);
      chk("R1 mid-run reset pc", pc, 8'h00);
      chk("R1 mid-run reset stage", stage, 2'd0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule